// File: doc/BRIEF.md
# SMRAM Access Control Decoder

This block sits in the address path of a memory controller and decides, for every processor or bus-master access, whether the access goes to the protected system-management RAM or to ordinary main memory. The management RAM is a 32 KB window that overlays main memory. By default it sits at 0x38000 through 0x3FFFF. Selection inside the window depends on the active-low management-mode signal, two software control bits and the identity of the requesting bus master, not on the address alone.

A pending base register can be reloaded at any time. The new base is applied only when the processor next enters management mode, and only if it is 32 KB aligned. A misaligned base raises a sticky halt request and leaves the old window in place. Each edge of the management-mode signal produces a one-cycle cache-flush request, so that caches holding overlaid data are emptied when the mode changes.

Top module: `smram_gate`

## Requirements
- R1: After reset, sram_cs, main_cs, deny, flush_req and halt_req are all 0. The control bits are cleared and the pending base is 0x30000. The window is the 32 KB range from base+0x8000 through base+0xFFFF, with the handler entry at base+0x8000. It is therefore 0x38000–0x3FFFF after reset.
- R2: Outputs are registered. An access presented with rd_en or wr_en high in one cycle produces exactly one chip select in the next cycle. With neither strobe high, neither chip select is asserted. sram_cs and main_cs are never high together.
- R3: An access from the processor (master_id equal to CPU_ID, 0 by default) that hits the window while smi_act_n is 0 and the force-main bit is clear selects SRAM.
- R4: Outside management mode, a window hit selects main memory unless the open bit (control bit 0) is set. With the open bit set, a processor hit selects SRAM.
- R5: Inside management mode, setting force-main (control bit 1) sends window hits to main memory.
- R6: An access from any master other than CPU_ID never asserts sram_cs. If that access would otherwise have selected SRAM, it asserts main_cs and a deny pulse lasting one cycle.
- R7: Addresses outside the window always select main memory.
- R8: A write with cfg_wr=1 and cfg_sel=1 loads the pending base. The active base changes only on a 1-to-0 edge of smi_act_n, so a base written during management mode has no effect until the next entry.
- R9: On entry, a pending base with any of bits [14:0] set is not applied. Instead halt_req rises and stays high until reset.
- R10: Each change of smi_act_n produces flush_req high for exactly one cycle, in the cycle after the change is clocked in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Access address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| master_id | input | MID_W | Requesting bus master |
| smi_act_n | input | 1 | Management mode active, low true |
| cfg_wr | input | 1 | Control/base register write strobe |
| cfg_sel | input | 1 | 0 selects control bits, 1 selects pending base |
| cfg_wdata | input | ADDR_W | Register write data |
| sram_cs | output | 1 | Management RAM select |
| main_cs | output | 1 | Main memory select |
| deny | output | 1 | Alternate master blocked from window |
| flush_req | output | 1 | Cache flush request pulse |
| halt_req | output | 1 | Misaligned base shutdown indication |

## Verification
The assertions check on every cycle that the two chip selects are exclusive and that an idle cycle selects nothing. They also check that an alternate master never reaches SRAM, that a deny pulse always comes with a main-memory select, that every mode edge is followed by a flush pulse, and that the halt request is sticky. Only the bench scenarios can show which memory a given address and mode should reach. Window boundaries, the open and force-main overrides, the deferral of a base change to the next entry, and the rejection of a misaligned base depend on sequences of configuration and mode changes, and the checker does not model those.

// File: rtl/smram_pkg.sv
package smram_pkg;

    typedef struct packed {
        logic open_win;
        logic force_main;
    } smram_ctrl_t;

    typedef struct packed {
        logic sram_cs;
        logic main_cs;
        logic deny;
    } smram_route_t;

    localparam int CTRL_OPEN_BIT  = 0;
    localparam int CTRL_FORCE_BIT = 1;

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] RESET_BASE = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output smram_ctrl_t       ctrl,
    output logic [ADDR_W-1:0] pending_base
);

    typedef struct packed {
        smram_ctrl_t       ctrl;
        logic [ADDR_W-1:0] pend;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (cfg_sel) begin
                st_d.pend = cfg_wdata;
            end else begin
                st_d.ctrl.open_win   = cfg_wdata[CTRL_OPEN_BIT];
                st_d.ctrl.force_main = cfg_wdata[CTRL_FORCE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.pend <= ADDR_W'(RESET_BASE);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl         = st_q.ctrl;
    assign pending_base = st_q.pend;

endmodule

// File: rtl/smram_base_ctl.sv
module smram_base_ctl #(
    parameter int          ADDR_W     = 32,
    parameter int          WIN_SHIFT  = 15,
    parameter logic [31:0] RESET_BASE = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_act_n,
    input  logic [ADDR_W-1:0] pending_base,
    output logic [ADDR_W-1:0] active_base,
    output logic              flush_req,
    output logic              halt_req
);

    typedef struct packed {
        logic              smi_prev;
        logic [ADDR_W-1:0] base;
        logic              flush;
        logic              halt;
    } base_state_t;

    base_state_t st_d, st_q;
    logic entry;
    logic aligned;

    always_comb begin
        entry   = st_q.smi_prev && !smi_act_n;
        aligned = (pending_base[WIN_SHIFT-1:0] == '0);
        st_d          = st_q;
        st_d.smi_prev = smi_act_n;
        st_d.flush    = (st_q.smi_prev != smi_act_n);
        if (entry) begin
            if (aligned) st_d.base = pending_base;
            else         st_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.smi_prev <= 1'b1;
            st_q.base     <= ADDR_W'(RESET_BASE);
            st_q.flush    <= 1'b0;
            st_q.halt     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_base = st_q.base;
    assign flush_req   = st_q.flush;
    assign halt_req    = st_q.halt;

endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MID_W     = 4,
    parameter int CPU_ID    = 0,
    parameter int WIN_SHIFT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [MID_W-1:0]  master_id,
    input  logic              smi_act_n,
    input  smram_ctrl_t       ctrl,
    input  logic [ADDR_W-1:0] active_base,
    output smram_route_t      route
);

    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(1) << WIN_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_LAST  = WIN_BYTES - ADDR_W'(1);

    smram_route_t st_d, st_q;
    logic [ADDR_W-1:0] win_lo;
    logic [ADDR_W-1:0] win_hi;
    logic hit, access, is_cpu, in_smm, want_sram;

    always_comb begin
        win_lo    = active_base + WIN_BYTES;
        win_hi    = win_lo + WIN_LAST;
        hit       = (addr >= win_lo) && (addr <= win_hi);
        access    = rd_en || wr_en;
        is_cpu    = (master_id == MID_W'(CPU_ID));
        in_smm    = !smi_act_n;
        want_sram = hit && ((in_smm && !ctrl.force_main) ||
                            (!in_smm && ctrl.open_win));
        st_d = '0;
        if (access) begin
            if (want_sram && is_cpu) begin
                st_d.sram_cs = 1'b1;
            end else begin
                st_d.main_cs = 1'b1;
                st_d.deny    = want_sram;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route = st_q;

endmodule

// File: rtl/smram_gate.sv
module smram_gate
    import smram_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          MID_W      = 4,
    parameter int          CPU_ID     = 0,
    parameter int          WIN_SHIFT  = 15,
    parameter logic [31:0] RESET_BASE = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [MID_W-1:0]  master_id,
    input  logic              smi_act_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              sram_cs,
    output logic              main_cs,
    output logic              deny,
    output logic              flush_req,
    output logic              halt_req
);

    smram_ctrl_t       ctrl;
    smram_route_t      route;
    logic [ADDR_W-1:0] pending_base;
    logic [ADDR_W-1:0] active_base;

    smram_cfg_regs #(.ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl(ctrl), .pending_base(pending_base)
    );

    smram_base_ctl #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT),
                     .RESET_BASE(RESET_BASE)) u_base (
        .clk(clk), .rst_n(rst_n), .smi_act_n(smi_act_n),
        .pending_base(pending_base), .active_base(active_base),
        .flush_req(flush_req), .halt_req(halt_req)
    );

    smram_route #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CPU_ID(CPU_ID),
                  .WIN_SHIFT(WIN_SHIFT)) u_route (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .master_id(master_id), .smi_act_n(smi_act_n),
        .ctrl(ctrl), .active_base(active_base), .route(route)
    );

    assign sram_cs = route.sram_cs;
    assign main_cs = route.main_cs;
    assign deny    = route.deny;

endmodule

// File: rtl/smram_gate_chk.sv
module smram_gate_chk #(
    parameter int MID_W  = 4,
    parameter int CPU_ID = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic [MID_W-1:0] master_id,
    input logic             smi_act_n,
    input logic             sram_cs,
    input logic             main_cs,
    input logic             deny,
    input logic             flush_req,
    input logic             halt_req
);

    a_r2_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_cs && main_cs));

    a_r2_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |=> !(sram_cs || main_cs));

    a_r6_dma_no_sram: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && master_id != MID_W'(CPU_ID)) |=> !sram_cs);

    a_r6_deny_goes_main: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> main_cs);

    a_r10_flush_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_act_n != $past(smi_act_n)) |=> flush_req);

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> halt_req);

endmodule

bind smram_gate smram_gate_chk #(.MID_W(MID_W), .CPU_ID(CPU_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .master_id(master_id), .smi_act_n(smi_act_n), .sram_cs(sram_cs),
    .main_cs(main_cs), .deny(deny), .flush_req(flush_req),
    .halt_req(halt_req)
);

// File: tb/smram_gate_test.sv
module smram_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0]  master_id = '0;
    logic        smi_act_n = 1'b1;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic sram_cs, main_cs, deny, flush_req, halt_req;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    smram_gate uut (.*);

    // Output vector order: {sram_cs, main_cs, deny, flush_req, halt_req}
    task automatic chk(string req, logic [4:0] exp);
        logic [4:0] got;
        got = {sram_cs, main_cs, deny, flush_req, halt_req};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (sram,main,deny,flush,halt)",
                     req, got, exp);
        end
    endtask

    task automatic cfg(logic sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic acc(string req, logic [31:0] a, logic [3:0] mid, logic [4:0] exp);
        @(negedge clk);
        addr = a; master_id = mid; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, exp);
    endtask

    task automatic smi(string req, logic lvl, logic halt);
        @(negedge clk);
        smi_act_n = lvl;
        @(negedge clk);
        chk(req, {3'b000, 1'b1, halt});
        @(negedge clk);
        chk(req, {3'b000, 1'b0, halt});
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", 5'b00000);
        acc("R1 R4 reset window closed 0x38000", 32'h38000, 0, 5'b01000);
    endtask

    task automatic t_smm_basic();
        smi("R10 entry flush", 1'b0, 1'b0);
        acc("R1 R3 window low edge", 32'h38000, 0, 5'b10000);
        acc("R3 window high edge", 32'h3FFFF, 0, 5'b10000);
        acc("R7 below window", 32'h37FFF, 0, 5'b01000);
        acc("R7 above window", 32'h40000, 0, 5'b01000);
        acc("R6 dma denied", 32'h3A000, 4'h3, 5'b01100);
        @(negedge clk);
        chk("R2 R6 idle after deny", 5'b00000);
        acc("R6 dma outside window", 32'h50000, 4'h3, 5'b01000);
        cfg(1'b0, 32'h2);
        acc("R5 force main", 32'h38000, 0, 5'b01000);
        cfg(1'b0, 32'h0);
        acc("R5 force cleared", 32'h38000, 0, 5'b10000);
        smi("R10 exit flush", 1'b1, 1'b0);
        acc("R4 closed outside mode", 32'h38000, 0, 5'b01000);
    endtask

    task automatic t_open();
        cfg(1'b0, 32'h1);
        acc("R4 open cpu", 32'h38000, 0, 5'b10000);
        acc("R6 open dma denied", 32'h38000, 4'h1, 5'b01100);
        cfg(1'b0, 32'h0);
        acc("R4 closed again", 32'h38000, 0, 5'b01000);
    endtask

    task automatic t_relocate();
        cfg(1'b1, 32'h50000);
        acc("R8 not applied before entry", 32'h38000, 0, 5'b01000);
        smi("R10 entry flush", 1'b0, 1'b0);
        acc("R8 new window", 32'h58000, 0, 5'b10000);
        acc("R8 old window gone", 32'h38000, 0, 5'b01000);
        cfg(1'b1, 32'h60000);
        acc("R8 deferred during mode", 32'h58000, 0, 5'b10000);
        smi("R10 exit flush", 1'b1, 1'b0);
        smi("R10 entry flush", 1'b0, 1'b0);
        acc("R8 applied at entry", 32'h68000, 0, 5'b10000);
        smi("R10 exit flush", 1'b1, 1'b0);
    endtask

    task automatic t_misaligned();
        cfg(1'b1, 32'h61000);
        @(negedge clk);
        chk("R9 no halt before entry", 5'b00000);
        smi("R9 halt at entry", 1'b0, 1'b1);
        acc("R9 base kept", 32'h68000, 0, 5'b10001);
        @(negedge clk); @(negedge clk);
        chk("R9 halt sticky", 5'b00001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_smm_basic();
        t_open();
        t_relocate();
        t_misaligned();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule